// File: doc/BRIEF.md
# Banked Interrupt Controller with Round-Robin Next-Source Lookup

This block collects 128 interrupt request lines, split into four banks of 32, and turns them into two processor-facing lines: a normal interrupt and a fast interrupt. Each request is latched into a sticky pending bit. Software enables sources through a per-bank enable word and picks the output line for each source through a per-bank route word. It acknowledges a source by writing a one to that source's position in the bank's acknowledge register. Source n lives in bank n>>5 at bit n mod 32. A parameter sets each bank to capture either rising edges or levels.

Each bank has a 16-byte register window: pending at byte offset 0, acknowledge at 4, enable at 8 and route at 12. Bank k starts at byte 16·k. A combinational lookup port helps the handler pick the next source fairly. Given the index last serviced, it returns the first pending and enabled source found by scanning upward from the following index, wrapping from 127 to 0. A source that fires all the time therefore cannot hide the others.

Top module: `rr_irq_ctrl`

## Requirements
- R1: After reset every pending, enable and route bit is 0, both interrupt outputs are low and the lookup reports no source (valid 0, index 0).
- R2: In an edge bank (bank 0 by default) a pending bit is set only on a 0-to-1 change of its request. A request held high after an acknowledge does not set the bit again.
- R3: In a level bank (banks 1 to 3 by default) a pending bit is set in every cycle its request is high. An acknowledge has no effect while the request stays high. The bit stays set after the request falls, until it is acknowledged.
- R4: Writing word W to a bank's acknowledge register (byte offset 4) clears each pending bit whose position is 1 in W. Positions written as 0 keep their value.
- R5: When a set and an acknowledge of the same pending bit fall in the same cycle, the bit ends up set.
- R6: Reading byte offset 0 of bank k returns its raw pending bits whatever the enable word holds. Offsets 8 and 12 read back the enable word (1 = enabled) and the route word (0 = normal line, 1 = fast line) last written. Bank k is at byte address 16·k + offset.
- R7: One clock after the pending, enable and route state changes, the normal output is high exactly when some source is pending, enabled and routed 0. The fast output is high exactly when some source is pending, enabled and routed 1.
- R8: In the same cycle as its inputs, the lookup returns, for a last index L, the first index among (L+1) mod 128, (L+2) mod 128, … that is both pending and enabled. L itself is examined last, and disabled sources are skipped.
- R9: When no source is both pending and enabled, the lookup gives valid 0 and index 0.
- R10: Reads of the acknowledge offset, of addresses whose low two bits are not 00, and of addresses at or beyond 16·(number of banks) return 0. Writes to those addresses, and writes to the pending offset, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| irq_src_i | input | 128 | Interrupt requests, synchronous to clk_i |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| last_idx_i | input | 7 | Index last serviced, the starting point for the lookup |
| next_idx_o | output | 7 | Next source to service |
| next_valid_o | output | 1 | Lookup found a pending and enabled source |
| norm_irq_o | output | 1 | Registered normal interrupt line |
| fast_irq_o | output | 1 | Registered fast interrupt line |

## Verification
A request sampled at a clock edge, or a register write taken there, is visible on the pending, enable and route readback and on the lookup outputs right after that same edge, with no added delay. The two interrupt lines follow one edge later because of their output register. The bench drives every input on the falling edge and samples just after the next falling edge. It checks each interrupt line once at the point where it must still hold the old value and again one cycle later where it must hold the new one, so an extra or a missing register stage is caught. Lookup results are read 1 ns after the last index is applied, since the lookup has no register.

// File: rtl/rr_irq_pkg.sv
// Package: shared constants and the register-select encoding for the
// banked interrupt controller. Assumes a 32-bit register port.
package rr_irq_pkg;

    localparam int REG_W       = 32;   // register data width
    localparam int BANK_BYTES  = 16;   // register window per bank
    localparam int SEL_LSB     = 2;    // word select within a bank window
    localparam int BANK_LSB    = 4;    // bank select starts here

    // Word within a bank window, in address order.
    typedef enum logic [1:0] {
        RSEL_PEND  = 2'd0,   // raw pending bits, read only
        RSEL_ACK   = 2'd1,   // write ones to clear, reads zero
        RSEL_EN    = 2'd2,   // enable word
        RSEL_ROUTE = 2'd3    // route word: 0 normal, 1 fast
    } rsel_e;

endpackage

// File: rtl/rr_irq_bank.sv
// Module: rr_irq_bank
// One bank of interrupt sources: request capture (edge or level, chosen by
// IS_LEVEL), sticky pending bits with write-ones-to-clear, enable word and
// route word. Assumes requests are already synchronous to clk_i.
// A set in the same cycle as a clear of the same bit wins.
module rr_irq_bank #(
    parameter int WIDTH    = 32,
    parameter bit IS_LEVEL = 1'b0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] src_i,
    input  logic             ack_we_i,
    input  logic             en_we_i,
    input  logic             route_we_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] pend_o,
    output logic [WIDTH-1:0] en_o,
    output logic [WIDTH-1:0] route_o
);

    logic [WIDTH-1:0] set_vec;
    logic [WIDTH-1:0] clr_vec;

    generate
        if (IS_LEVEL) begin : g_level
            // Level capture: a high request sets the bit every cycle.
            assign set_vec = src_i;
        end else begin : g_edge
            logic [WIDTH-1:0] src_q;

            // Remember last cycle's requests for rising-edge detection.
            always_ff @(posedge clk_i) begin
                if (!rst_ni) src_q <= '0;
                else         src_q <= src_i;
            end

            assign set_vec = src_i & ~src_q;
        end
    endgenerate

    assign clr_vec = ack_we_i ? wdata_i : '0;

    // Sticky pending bits: clear by ones written, then new sets win.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) pend_o <= '0;
        else         pend_o <= (pend_o & ~clr_vec) | set_vec;
    end

    // Enable word, loaded whole by a register write.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)      en_o <= '0;
        else if (en_we_i) en_o <= wdata_i;
    end

    // Route word, loaded whole by a register write.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)         route_o <= '0;
        else if (route_we_i) route_o <= wdata_i;
    end

endmodule

// File: rtl/rr_irq_finder.sv
// Module: rr_irq_finder
// Combinational round-robin search: rotates the active vector so that
// index (last+1) mod N lands at bit 0, takes the lowest set bit, and
// rotates the position back. The last index itself is examined last.
// Assumes N >= 2. Reports index 0 with valid 0 when nothing is active.
module rr_irq_finder #(
    parameter int N = 128
) (
    input  logic [N-1:0]         active_i,
    input  logic [$clog2(N)-1:0] last_i,
    output logic [$clog2(N)-1:0] idx_o,
    output logic                 valid_o
);

    localparam int IW  = $clog2(N);
    localparam int IW1 = IW + 1;

    logic [IW-1:0]  start;
    logic [N-1:0]   rot;
    logic [IW-1:0]  pos;
    logic           found;
    logic [IW1-1:0] sum;

    // Search start point, wrapping after the top index.
    assign start = (last_i == IW'(N - 1)) ? '0 : last_i + 1'b1;

    // Rotate the active set right so the start point sits at bit 0.
    assign rot = N'({active_i, active_i} >> start);

    // Lowest set bit of the rotated vector.
    always_comb begin
        pos   = '0;
        found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (rot[i]) begin
                pos   = IW'(i);
                found = 1'b1;
            end
        end
    end

    // Map the rotated position back to a source index.
    always_comb begin
        sum = {1'b0, start} + {1'b0, pos};
        if (sum >= IW1'(N)) sum = sum - IW1'(N);
        idx_o   = found ? sum[IW-1:0] : '0;
        valid_o = found;
    end

endmodule

// File: rtl/rr_irq_ctrl.sv
// Module: rr_irq_ctrl (top)
// Banked interrupt controller: NUM_BANKS banks of SRC_PER_BANK sources
// behind a word-aligned byte-addressed register port. Each bank has a
// 16-byte window (pending, acknowledge, enable, route). Drives registered
// normal and fast interrupt lines and a combinational round-robin lookup.
// Assumes SRC_PER_BANK == 32 (one register word), NUM_BANKS >= 2,
// ADDR_W large enough to hold 16*NUM_BANKS, and synchronous requests.
module rr_irq_ctrl
    import rr_irq_pkg::*;
#(
    parameter int                   NUM_BANKS     = 4,
    parameter int                   SRC_PER_BANK  = 32,
    parameter int                   ADDR_W        = 8,
    parameter logic [NUM_BANKS-1:0] BANK_IS_LEVEL = 4'b1110
) (
    input  logic                                        clk_i,
    input  logic                                        rst_ni,
    input  logic [NUM_BANKS*SRC_PER_BANK-1:0]           irq_src_i,
    input  logic                                        reg_wr_i,
    input  logic [ADDR_W-1:0]                           reg_addr_i,
    input  logic [REG_W-1:0]                            reg_wdata_i,
    output logic [REG_W-1:0]                            reg_rdata_o,
    input  logic [$clog2(NUM_BANKS*SRC_PER_BANK)-1:0]   last_idx_i,
    output logic [$clog2(NUM_BANKS*SRC_PER_BANK)-1:0]   next_idx_o,
    output logic                                        next_valid_o,
    output logic                                        norm_irq_o,
    output logic                                        fast_irq_o
);

    localparam int NUM_SRC   = NUM_BANKS * SRC_PER_BANK;
    localparam int ADDR_HI_W = ADDR_W - BANK_LSB;

    logic [NUM_BANKS-1:0][SRC_PER_BANK-1:0] pend_b;
    logic [NUM_BANKS-1:0][SRC_PER_BANK-1:0] en_b;
    logic [NUM_BANKS-1:0][SRC_PER_BANK-1:0] route_b;
    logic [NUM_SRC-1:0]   pend_all;
    logic [NUM_SRC-1:0]   mask_all;
    logic [NUM_SRC-1:0]   route_all;
    logic [NUM_SRC-1:0]   lvl_vec;
    logic [NUM_BANKS-1:0] bank_hit;
    logic                 aligned;
    logic [ADDR_HI_W-1:0] addr_hi;
    rsel_e                rsel;

    assign aligned = (reg_addr_i[SEL_LSB-1:0] == '0);
    assign addr_hi = reg_addr_i[ADDR_W-1:BANK_LSB];
    assign rsel    = rsel_e'(reg_addr_i[BANK_LSB-1:SEL_LSB]);

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic ack_we;
            logic en_we;
            logic route_we;

            assign bank_hit[b] = aligned && (addr_hi == ADDR_HI_W'(b));
            assign ack_we      = reg_wr_i && bank_hit[b] && (rsel == RSEL_ACK);
            assign en_we       = reg_wr_i && bank_hit[b] && (rsel == RSEL_EN);
            assign route_we    = reg_wr_i && bank_hit[b] && (rsel == RSEL_ROUTE);

            rr_irq_bank #(
                .WIDTH    (SRC_PER_BANK),
                .IS_LEVEL (BANK_IS_LEVEL[b])
            ) u_bank (
                .clk_i      (clk_i),
                .rst_ni     (rst_ni),
                .src_i      (irq_src_i[b*SRC_PER_BANK +: SRC_PER_BANK]),
                .ack_we_i   (ack_we),
                .en_we_i    (en_we),
                .route_we_i (route_we),
                .wdata_i    (reg_wdata_i[SRC_PER_BANK-1:0]),
                .pend_o     (pend_b[b]),
                .en_o       (en_b[b]),
                .route_o    (route_b[b])
            );

            assign pend_all [b*SRC_PER_BANK +: SRC_PER_BANK] = pend_b[b];
            assign mask_all [b*SRC_PER_BANK +: SRC_PER_BANK] = en_b[b];
            assign route_all[b*SRC_PER_BANK +: SRC_PER_BANK] = route_b[b];
            assign lvl_vec  [b*SRC_PER_BANK +: SRC_PER_BANK] =
                {SRC_PER_BANK{BANK_IS_LEVEL[b]}};
        end
    endgenerate

    // Read mux: selected bank word, zero for acknowledge and unused addresses.
    always_comb begin
        reg_rdata_o = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_hit[b]) begin
                case (rsel)
                    RSEL_PEND:  reg_rdata_o[SRC_PER_BANK-1:0] = pend_b[b];
                    RSEL_EN:    reg_rdata_o[SRC_PER_BANK-1:0] = en_b[b];
                    RSEL_ROUTE: reg_rdata_o[SRC_PER_BANK-1:0] = route_b[b];
                    default:    reg_rdata_o = '0;
                endcase
            end
        end
    end

    // Round-robin lookup over pending and enabled sources.
    rr_irq_finder #(
        .N (NUM_SRC)
    ) u_finder (
        .active_i (pend_all & mask_all),
        .last_i   (last_idx_i),
        .idx_o    (next_idx_o),
        .valid_o  (next_valid_o)
    );

    // Glitch-free interrupt lines, split by route bit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            norm_irq_o <= 1'b0;
            fast_irq_o <= 1'b0;
        end else begin
            norm_irq_o <= |(pend_all & mask_all & ~route_all);
            fast_irq_o <= |(pend_all & mask_all &  route_all);
        end
    end

endmodule

// File: rtl/rr_irq_ctrl_chk.sv
// Module: rr_irq_ctrl_chk
// Property checker for rr_irq_ctrl, attached by bind. Observes the ports
// and the bank state vectors, and checks the lookup, the output lines and
// level capture against them.
module rr_irq_ctrl_chk #(
    parameter int N  = 128,
    parameter int IW = 7
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic [N-1:0]  irq_src_i,
    input logic [N-1:0]  pend_all,
    input logic [N-1:0]  mask_all,
    input logic [N-1:0]  route_all,
    input logic [N-1:0]  lvl_vec,
    input logic [IW-1:0] next_idx_o,
    input logic          next_valid_o,
    input logic          norm_irq_o,
    input logic          fast_irq_o
);

    logic [N-1:0] act;
    assign act = pend_all & mask_all;

    // R8: a reported source is pending and enabled.
    p_found_active_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        next_valid_o |-> act[next_idx_o]);

    // R8: any pending and enabled source makes the lookup valid.
    p_active_found_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act != '0) |-> next_valid_o);

    // R9: nothing active gives valid 0 and index 0.
    p_none_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act == '0) |-> (!next_valid_o && next_idx_o == '0));

    // R7: normal line follows active normal-routed sources one clock later.
    p_norm_up_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(act & ~route_all)) |=> norm_irq_o);
    p_norm_down_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(|(act & ~route_all)) |=> !norm_irq_o);

    // R7: fast line follows active fast-routed sources one clock later.
    p_fast_up_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(act & route_all)) |=> fast_irq_o);
    p_fast_down_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(|(act & route_all)) |=> !fast_irq_o);

    // R3, R5: a high level request is pending the cycle after it is seen.
    p_level_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> ((($past(irq_src_i) & lvl_vec) & ~pend_all) == '0));

endmodule

bind rr_irq_ctrl rr_irq_ctrl_chk #(
    .N  (NUM_BANKS * SRC_PER_BANK),
    .IW ($clog2(NUM_BANKS * SRC_PER_BANK))
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .irq_src_i    (irq_src_i),
    .pend_all     (pend_all),
    .mask_all     (mask_all),
    .route_all    (route_all),
    .lvl_vec      (lvl_vec),
    .next_idx_o   (next_idx_o),
    .next_valid_o (next_valid_o),
    .norm_irq_o   (norm_irq_o),
    .fast_irq_o   (fast_irq_o)
);

// File: tb/rr_irq_ctrl_tb_top.sv
// Directed bench for rr_irq_ctrl: one task per scenario, each checking
// its own results. Inputs change on the falling edge; outputs are sampled
// after the falling edge that follows the rising edge of interest.
module rr_irq_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] src = '0;
    logic         wr = 1'b0;
    logic [7:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic [6:0]   last_idx = '0;
    logic [6:0]   nidx;
    logic         nvalid;
    logic         irq_n;
    logic         irq_f;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rr_irq_ctrl dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .irq_src_i    (src),
        .reg_wr_i     (wr),
        .reg_addr_i   (addr),
        .reg_wdata_i  (wdata),
        .reg_rdata_o  (rdata),
        .last_idx_i   (last_idx),
        .next_idx_o   (nidx),
        .next_valid_o (nvalid),
        .norm_irq_o   (irq_n),
        .fast_irq_o   (irq_f)
    );

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
        addr = '0;
    endtask

    task automatic pulse(input int i);
        @(negedge clk);
        src[i] = 1'b1;
        @(negedge clk);
        src[i] = 1'b0;
    endtask

    task automatic look(input logic [6:0] last, input logic v,
                        input logic [6:0] idx, input string tag);
        last_idx = last;
        #1;
        check(tag, {31'd0, nvalid}, {31'd0, v});
        check(tag, {25'd0, nidx}, {25'd0, idx});
    endtask

    task automatic cleanup();
        src = '0;
        for (int b = 0; b < 4; b++) begin
            wr_reg(8'(b * 16 + 8), 32'h0);
            wr_reg(8'(b * 16 + 12), 32'h0);
            wr_reg(8'(b * 16 + 4), 32'hFFFF_FFFF);
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int b = 0; b < 4; b++) begin
            for (int o = 0; o < 16; o += 4) begin
                rd_reg(8'(b * 16 + o), d);
                check("R1 reset register", d, 32'h0);
            end
        end
        check("R1 reset normal line", {31'd0, irq_n}, 32'h0);
        check("R1 reset fast line", {31'd0, irq_f}, 32'h0);
        look(7'd0, 1'b0, 7'd0, "R1 reset lookup");
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        for (int b = 0; b < 4; b++) begin
            wr_reg(8'(b * 16 + 8), 32'hA500_0000 | 32'(b));
            wr_reg(8'(b * 16 + 12), 32'h00C3_0000 | (32'(b) << 8));
        end
        wr_reg(8'h20, 32'hFFFF_FFFF);      // pending word of bank 2: ignored
        wr_reg(8'h19, 32'hFFFF_FFFF);      // unaligned: ignored
        wr_reg(8'h48, 32'hFFFF_FFFF);      // beyond bank 3: ignored
        for (int b = 0; b < 4; b++) begin
            rd_reg(8'(b * 16 + 8), d);
            check("R6 enable readback", d, 32'hA500_0000 | 32'(b));
            rd_reg(8'(b * 16 + 12), d);
            check("R6 route readback", d, 32'h00C3_0000 | (32'(b) << 8));
            rd_reg(8'(b * 16 + 4), d);
            check("R10 ack reads zero", d, 32'h0);
        end
        rd_reg(8'h20, d);
        check("R10 pending write ignored", d, 32'h0);
        rd_reg(8'h19, d);
        check("R10 unaligned reads zero", d, 32'h0);
        rd_reg(8'h48, d);
        check("R10 out of range reads zero", d, 32'h0);
        cleanup();
    endtask

    task automatic t_edge();
        logic [31:0] d;
        @(negedge clk);
        src[3] = 1'b1;
        repeat (3) @(negedge clk);
        rd_reg(8'h00, d);
        check("R2 edge captured", d, 32'h0000_0008);
        wr_reg(8'h04, 32'h0000_0008);
        @(negedge clk);
        rd_reg(8'h00, d);
        check("R2 held high no re-set", d, 32'h0);
        src[3] = 1'b0;
        pulse(5);
        pulse(7);
        rd_reg(8'h00, d);
        check("R2 two pulses", d, 32'h0000_00A0);
        wr_reg(8'h04, 32'h0000_0020);
        rd_reg(8'h00, d);
        check("R4 partial clear", d, 32'h0000_0080);
        cleanup();
    endtask

    task automatic t_level();
        logic [31:0] d;
        @(negedge clk);
        src[40] = 1'b1;
        @(negedge clk);
        rd_reg(8'h10, d);
        check("R3 level captured", d, 32'h0000_0100);
        wr_reg(8'h14, 32'h0000_0100);
        rd_reg(8'h10, d);
        check("R3 ack while high", d, 32'h0000_0100);
        src[40] = 1'b0;
        @(negedge clk);
        rd_reg(8'h10, d);
        check("R3 sticky after fall", d, 32'h0000_0100);
        wr_reg(8'h14, 32'h0000_0100);
        rd_reg(8'h10, d);
        check("R3 ack after fall", d, 32'h0);
        cleanup();
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        @(negedge clk);
        wr = 1'b1; addr = 8'h04; wdata = 32'h0000_0004; src[2] = 1'b1;
        @(negedge clk);
        wr = 1'b0; addr = '0; wdata = '0; src[2] = 1'b0;
        rd_reg(8'h00, d);
        check("R5 set beats clear", d, 32'h0000_0004);
        wr_reg(8'h04, 32'h0000_0004);
        rd_reg(8'h00, d);
        check("R5 later clear works", d, 32'h0);
        cleanup();
    endtask

    task automatic t_outputs();
        logic [31:0] d;
        pulse(10);
        @(negedge clk);
        check("R7 masked normal line", {31'd0, irq_n}, 32'h0);
        check("R7 masked fast line", {31'd0, irq_f}, 32'h0);
        rd_reg(8'h00, d);
        check("R6 raw pending while masked", d, 32'h0000_0400);
        look(7'd0, 1'b0, 7'd0, "R8 masked source skipped");
        wr_reg(8'h08, 32'h0000_0400);
        check("R7 normal line one cycle late", {31'd0, irq_n}, 32'h0);
        @(negedge clk);
        check("R7 normal line up", {31'd0, irq_n}, 32'h1);
        check("R7 fast line idle", {31'd0, irq_f}, 32'h0);
        wr_reg(8'h0C, 32'h0000_0400);
        @(negedge clk);
        check("R7 routed away from normal", {31'd0, irq_n}, 32'h0);
        check("R7 fast line up", {31'd0, irq_f}, 32'h1);
        wr_reg(8'h08, 32'h0);
        @(negedge clk);
        check("R7 fast line down", {31'd0, irq_f}, 32'h0);
        cleanup();
    endtask

    task automatic t_lookup();
        pulse(5);
        pulse(70);
        pulse(127);
        for (int b = 0; b < 4; b++) wr_reg(8'(b * 16 + 8), 32'hFFFF_FFFF);
        look(7'd5,   1'b1, 7'd70,  "R8 after 5");
        look(7'd70,  1'b1, 7'd127, "R8 after 70");
        look(7'd127, 1'b1, 7'd5,   "R8 wrap after 127");
        look(7'd4,   1'b1, 7'd5,   "R8 next neighbour");
        look(7'd6,   1'b1, 7'd70,  "R8 cross bank");
        wr_reg(8'h28, 32'hFFFF_FFBF);
        look(7'd6,   1'b1, 7'd127, "R8 disabled skipped");
        wr_reg(8'h34, 32'h8000_0000);
        wr_reg(8'h24, 32'h0000_0040);
        look(7'd5,   1'b1, 7'd5,   "R8 last examined last");
        look(7'd127, 1'b1, 7'd5,   "R8 single source");
        wr_reg(8'h04, 32'hFFFF_FFFF);
        look(7'd5,   1'b0, 7'd0,   "R9 none pending");
        pulse(32);
        look(7'd31,  1'b1, 7'd32,  "R8 bank boundary");
        look(7'd32,  1'b1, 7'd32,  "R8 boundary self");
        cleanup();
        look(7'd0,   1'b0, 7'd0,   "R9 idle after cleanup");
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_edge();
        t_level();
        t_set_wins();
        t_outputs();
        t_lookup();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule